// File: doc/BRIEF.md
# Sequential CRC Long-Division Engine

This block finds the 3-bit CRC remainder of a 14-bit message by carrying out modulo-2 long division one step per clock. A start pulse latches the message and a 4-bit generator polynomial. The message goes into a 17-bit dividend register with three zero bits appended at the low end. The polynomial goes into a 17-bit aligned-divisor register, left-justified. On each working cycle the aligned divisor is XORed into the dividend if the dividend bit under the divisor's leading position is set. The divisor is then moved one place to the right.

The work ends when the upper 14 bits of the dividend are all zero, or when the divisor has been moved past every message position. At that point the low three bits of the dividend are registered onto the CRC output. That output holds until the next computation completes. The controller then returns to idle and waits for the next start.

Top module: `crc_div_engine`

## Requirements
- R1: A synchronous active-high reset returns the engine to idle and clears the CRC output to 000.
- R2: In idle, with start low, the engine does nothing and the CRC output keeps its value. A computation begins on the first clock edge at which start is sampled high.
- R3: On start, the dividend is loaded as {message, 000} and the aligned divisor as {polynomial, 13 zero bits}. Message and polynomial are read only at that edge, and later changes to them have no effect on the running computation.
- R4: On a working step k (k = 0 for the first step), the aligned divisor is XORed into the dividend only if dividend bit 16−k is 1.
- R5: After every working step, the aligned divisor moves right by one bit, shifting in zeros.
- R6: The computation ends at the first working cycle in which dividend bits 16..3 are all zero, or after 14 steps. The CRC output then takes dividend bits 2..0. When the polynomial MSB is 1, this equals (message·x³) mod polynomial.
- R7: Message 11010011101100 with polynomial 1011 gives CRC 100.
- R8: The CRC output changes only when a computation completes. It holds between completions.
- R9: The new CRC is visible no later than 20 clock cycles after start is sampled high.
- R10: An all-zero message finishes at once with CRC 000. An all-zero polynomial runs to the step limit and gives CRC 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a computation when sampled high in idle |
| msg_in | input | 14 | Message word |
| poly_in | input | 4 | Generator polynomial, MSB first |
| crc_out | output | 3 | Registered remainder |

## Verification
An error in the dividend or in the divisor alignment does not show up on its own. It only appears as a wrong remainder on crc_out, and only at the completion edge, at most 16 cycles after start. So each vector is compared against a remainder computed by a bit-serial reference, and the arrival time is measured separately. A stuck controller or a bad termination test shows up as a late result or a missing one. A leak of live inputs into the running datapath is exposed by changing the message and polynomial in mid-computation. A spurious load is exposed by watching crc_out stay fixed while the engine is idle.

// File: rtl/crc_div_pkg.sv
package crc_div_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WORK = 1'b1
  } crc_state_e;
endpackage

// File: rtl/crc_div_ctrl.sv
module crc_div_ctrl
  import crc_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic upper_zero,
  input  logic limit_hit,
  output logic load,
  output logic step_en,
  output logic finish
);
  crc_state_e state_q, state_d;

  // state register
  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // next-state and control decode
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step_en = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_WORK;
        end
      end
      ST_WORK: begin
        if (upper_zero || limit_hit) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // R2: idle without start stays idle
  a_r2_idle_waits: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
  // R6: a finish always leads back to idle
  a_r6_finish_to_idle: assert property (@(posedge clk) disable iff (rst)
    finish |=> (state_q == ST_IDLE));
endmodule

// File: rtl/crc_div_datapath.sv
module crc_div_datapath #(
  parameter int DATA_W = 14,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step_en,
  input  logic [DATA_W-1:0] msg_in,
  input  logic [DIV_W-1:0]  poly_in,
  output logic              upper_zero,
  output logic              limit_hit,
  output logic [DIV_W-2:0]  rem_bits
);
  localparam int CRC_W = DIV_W - 1;
  localparam int REG_W = DATA_W + CRC_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int PIV_W = $clog2(REG_W);

  logic [REG_W-1:0] dvd_q;   // dividend
  logic [REG_W-1:0] dsr_q;   // aligned divisor
  logic [CNT_W-1:0] step_q;
  logic [PIV_W-1:0] piv_idx;
  logic             piv_bit;

  assign piv_idx    = PIV_W'(REG_W - 1) - PIV_W'(step_q);
  assign piv_bit    = dvd_q[piv_idx];
  assign upper_zero = (dvd_q[REG_W-1:CRC_W] == '0);
  assign limit_hit  = (step_q == CNT_W'(DATA_W));
  assign rem_bits   = dvd_q[CRC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q  <= '0;
      dsr_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      dvd_q  <= {msg_in, {CRC_W{1'b0}}};
      dsr_q  <= {poly_in, {(REG_W-DIV_W){1'b0}}};
      step_q <= '0;
    end else if (step_en) begin
      if (piv_bit) dvd_q <= dvd_q ^ dsr_q;
      dsr_q  <= dsr_q >> 1;
      step_q <= step_q + 1'b1;
    end
  end

  // R3: load layout
  a_r3_load_layout: assert property (@(posedge clk) disable iff (rst)
    load |=> (dvd_q == {$past(msg_in), {CRC_W{1'b0}}}) &&
             (dsr_q == {$past(poly_in), {(REG_W-DIV_W){1'b0}}}));
  // R4: no XOR when the pivot bit is clear
  a_r4_no_xor_clear: assert property (@(posedge clk) disable iff (rst)
    (step_en && !piv_bit) |=> $stable(dvd_q));
  // R5: divisor moves right by one each step
  a_r5_shift_right: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (dsr_q == ($past(dsr_q) >> 1)));
  // R9: controller never steps past the message length
  a_r9_step_bound: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (step_q < CNT_W'(DATA_W)));
endmodule

// File: rtl/crc_div_out.sv
module crc_div_out #(
  parameter int CRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish,
  input  logic [CRC_W-1:0] rem_bits,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst)         crc_q <= '0;
    else if (finish) crc_q <= rem_bits;
  end

  // R8: output holds unless a computation completes
  a_r8_crc_holds: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(crc_q));
  // R6: completion publishes the remainder
  a_r6_publish: assert property (@(posedge clk) disable iff (rst)
    finish |=> (crc_q == $past(rem_bits)));
endmodule

// File: rtl/crc_div_engine.sv
module crc_div_engine #(
  parameter int DATA_W = 14,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] msg_in,
  input  logic [DIV_W-1:0]  poly_in,
  output logic [DIV_W-2:0]  crc_out
);
  localparam int CRC_W = DIV_W - 1;

  logic load, step_en, finish, upper_zero, limit_hit;
  logic [CRC_W-1:0] rem_bits;

  crc_div_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .upper_zero(upper_zero), .limit_hit(limit_hit),
    .load(load), .step_en(step_en), .finish(finish)
  );

  crc_div_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rst(rst), .load(load), .step_en(step_en),
    .msg_in(msg_in), .poly_in(poly_in),
    .upper_zero(upper_zero), .limit_hit(limit_hit), .rem_bits(rem_bits)
  );

  crc_div_out #(.CRC_W(CRC_W)) u_out (
    .clk(clk), .rst(rst), .finish(finish),
    .rem_bits(rem_bits), .crc_q(crc_out)
  );

  // R1: reset leaves the output cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (crc_out == '0));
endmodule

// File: tb/crc_div_engine_tb_top.sv
module crc_div_engine_tb_top;
  localparam int N_VEC = 6;
  localparam logic [13:0] V_MSG  [N_VEC] = '{14'b11010011101100, 14'b11000110000110,
                                             14'h3FFF, 14'h0001, 14'h2A55, 14'h1234};
  localparam logic [3:0]  V_POLY [N_VEC] = '{4'b1011, 4'b1011, 4'b1101, 4'b1011,
                                             4'b1111, 4'b1001};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [13:0] msg = '0;
  logic [3:0]  poly = '0;
  logic [2:0]  crc;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  crc_div_engine dut_i (.clk(clk), .rst(rst), .start(start),
                        .msg_in(msg), .poly_in(poly), .crc_out(crc));

  // bit-serial reference: (m * x^3) mod p, p MSB = 1
  function automatic logic [2:0] ref_crc(input logic [13:0] m, input logic [3:0] p);
    logic [2:0] r = '0;
    for (int i = 13; i >= 0; i--) begin
      logic fb = r[2] ^ m[i];
      r = {r[1:0], 1'b0} ^ (fb ? p[2:0] : 3'b000);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic run(input logic [13:0] m, input logic [3:0] p);
    @(negedge clk); msg = m; poly = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset value", crc, 3'b000);

        // R9: latency of the known vector
        begin
          int cyc = 0;
          @(negedge clk); msg = 14'b11010011101100; poly = 4'b1011; start = 1'b1;
          @(negedge clk); start = 1'b0; cyc = 1;
          while (crc !== 3'b100 && cyc < 30) begin @(negedge clk); cyc++; end
          n_chk++;
          if (cyc > 20) begin
            n_bad++;
            $display("FAIL R9: got %0d cycles expected <= 20", cyc);
          end
        end
        check("R7 known vector", crc, 3'b100);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < N_VEC; i++) begin
          run(V_MSG[i], V_POLY[i]);
          check("R6 table vector", crc, ref_crc(V_MSG[i], V_POLY[i]));
        end

        // R2 / R8: idle with start low, inputs moving
        run(14'h2A55, 4'b1111);
        msg = 14'h0155; poly = 4'b1001;
        repeat (25) @(negedge clk);
        check("R2 R8 idle hold", crc, ref_crc(14'h2A55, 4'b1111));

        // R3: inputs changed mid-computation are ignored
        @(negedge clk); msg = 14'b11010011101100; poly = 4'b1011; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        msg = 14'h3FFF; poly = 4'b1101;
        repeat (20) @(negedge clk);
        check("R3 mid-run inputs ignored", crc, 3'b100);

        // R10: zero message finishes with 000 quickly
        @(negedge clk); msg = '0; poly = 4'b1011; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 zero message", crc, 3'b000);

        // R10: zero polynomial hits the step limit, CRC 000
        run(14'b11010011101100, 4'b1011);
        run(14'h1234, 4'b0000);
        check("R10 zero polynomial", crc, 3'b000);

        // R1: reset mid-run clears the output
        run(14'b11010011101100, 4'b1011);
        @(negedge clk); msg = 14'h3FFF; poly = 4'b1101; start = 1'b1;
        @(negedge clk); start = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1 reset mid-run", crc, 3'b000);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule